// File: doc/BRIEF.md
# Input Change Detector with Bus-Deferred Interrupt

This block monitors a small group of input pins and reports any pin whose level has moved away from a stored reference. The reference is kept in a snapshot register. Each pin has a sticky change flag. The block also drives an active-low interrupt meant for an open-drain pad. A serial slave front end supplies four signals:

- a pulse when its own address is acknowledged;
- a pulse at each acknowledge that starts a new data/flag byte pair in a long read;
- a pulse on a STOP condition;
- a level that is high while a bus transaction is in progress.

Each acknowledge strobe reloads the snapshot from the live pins, clears every flag and releases the interrupt. While a transaction is running, a new change is not signalled at once. It is held as pending and raised at STOP, unless a later reload has already captured it into data sent to the master. A per-pin mask selects which pins may raise the interrupt. Flags record every pin whatever the mask.

Top module: `chg_watch`

## Requirements
- R1: After power-on reset (`por_n` low), with the pins equal to `SNAP_INIT` (default all ones), `flags_o` is 0 and `irq_n_o` is 1.
- R2: When idle (`busy_i` low), a pin that differs from the snapshot sets bit i of `flags_o` at the next clock edge. At the same edge `irq_n_o` goes to 0 if `mask_i[i]` is 1.
- R3: A flag stays set after its pin returns to the snapshot level. Only a reload or power-on reset clears it.
- R4: An `addr_ack_i` pulse loads the live pins into the snapshot, clears `flags_o` and drives `irq_n_o` to 1 at the next edge. Pins that differed before the pulse raise no flag afterwards.
- R5: An `rd_ack_i` pulse performs the same reload as R4, and it also discards any deferred interrupt.
- R6: A changed pin whose `mask_i` bit is 0 sets its flag but leaves `irq_n_o` at 1.
- R7: While `busy_i` is high, a masked change does not drive `irq_n_o` low. At the edge where `stop_i` is high, `irq_n_o` goes to 0.
- R8: If an `rd_ack_i` reload follows a deferred change and comes before STOP, `irq_n_o` stays 1 after STOP.
- R9: `stop_i` and `busy_i` alone neither clear flags nor release an asserted interrupt. Only `por_n` resets them without an acknowledge strobe.
- R10: A change that reverts within a transaction is still flagged, and it still raises the interrupt at STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pins_i | input | NPIN | Synchronised input pin levels |
| mask_i | input | NPIN | Per-pin interrupt enable |
| addr_ack_i | input | 1 | Own address acknowledged (one-cycle pulse) |
| rd_ack_i | input | 1 | Acknowledge starting a new read byte pair (pulse) |
| stop_i | input | 1 | STOP condition seen (pulse) |
| busy_i | input | 1 | Bus transaction in progress |
| flags_o | output | NPIN | Sticky per-pin change flags |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
The assertions check on every cycle that:

- the interrupt never falls while a transaction is running without a STOP;
- it only falls when a masked change or a pending change exists;
- every acknowledge strobe releases the interrupt and empties the flags;
- flags only grow between reloads.

Only the bench scenarios can show the sweeps over old and new pin patterns against every mask. They also show that a change read out before STOP raises nothing, that a glitch is retained, and that STOP and busy alone leave the flags and the interrupt untouched.

// File: rtl/chg_watch.sv
module chg_watch #(
  parameter int          NPIN      = 4,
  parameter logic [NPIN-1:0] SNAP_INIT = '1
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [NPIN-1:0] pins_i,
  input  logic [NPIN-1:0] mask_i,
  input  logic            addr_ack_i,
  input  logic            rd_ack_i,
  input  logic            stop_i,
  input  logic            busy_i,
  output logic [NPIN-1:0] flags_o,
  output logic            irq_n_o
);

  logic [NPIN-1:0] snap;
  logic [NPIN-1:0] diff;
  logic            reload, hit, irq_q, pend;

  assign diff    = pins_i ^ snap;
  assign reload  = addr_ack_i | rd_ack_i;
  assign hit     = |(diff & mask_i);
  assign irq_n_o = ~irq_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      snap    <= SNAP_INIT;
      flags_o <= '0;
      irq_q   <= 1'b0;
      pend    <= 1'b0;
    end else if (reload) begin
      snap    <= pins_i;
      flags_o <= '0;
      irq_q   <= 1'b0;
      pend    <= 1'b0;
    end else begin
      flags_o <= flags_o | diff;
      if (stop_i && (pend || hit)) begin
        irq_q <= 1'b1;
        pend  <= 1'b0;
      end else if (busy_i && hit) begin
        pend  <= 1'b1;
      end else if (!busy_i && hit) begin
        irq_q <= 1'b1;
      end
    end
  end

  assert_defer_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(irq_n_o) |-> $past(stop_i || !busy_i));

  assert_cause_R6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(irq_n_o) |-> $past(hit || pend));

  assert_release_R4: assert property (@(posedge clk) disable iff (!por_n)
    (addr_ack_i || rd_ack_i) |=> (irq_n_o && flags_o == '0));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
    !(addr_ack_i || rd_ack_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
    (!irq_n_o && !(addr_ack_i || rd_ack_i)) |=> !irq_n_o);

endmodule

// File: tb/chg_watch_tb_top.sv
module chg_watch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n;
  logic [3:0] pins, mask;
  logic       addr_ack, rd_ack, stop, busy;
  logic [3:0] flags;
  logic       irq_n;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_watch #(.NPIN(4), .SNAP_INIT(4'hF)) dut_i (
    .clk(clk), .por_n(por_n), .pins_i(pins), .mask_i(mask),
    .addr_ack_i(addr_ack), .rd_ack_i(rd_ack), .stop_i(stop), .busy_i(busy),
    .flags_o(flags), .irq_n_o(irq_n));

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; pins = 4'hF; mask = 4'hF;
    addr_ack = 0; rd_ack = 0; stop = 0; busy = 0;
    tick(); tick();
    por_n = 1'b1;
    tick(); tick();
    check("R1 flags", flags, 4'h0);
    check("R1 irq_n", {3'b0, irq_n}, 4'h1);

    // R2 R4 R6: idle sweep over old/new patterns and masks
    for (int m = 0; m < 16; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          mask = 4'(m); pins = 4'(a); addr_ack = 1; tick();
          addr_ack = 0;
          check("R4 flags after reload", flags, 4'h0);
          check("R4 irq_n after reload", {3'b0, irq_n}, 4'h1);
          pins = 4'(b); tick();
          check("R2 flags", flags, 4'(a ^ b));
          check("R6 irq_n", {3'b0, irq_n}, {3'b0, ~|(4'(a ^ b) & 4'(m))});
        end

    // R7: deferred until STOP
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        mask = 4'hF; pins = 4'(a); busy = 1; addr_ack = 1; tick();
        addr_ack = 0; pins = 4'(b); tick();
        tick();
        check("R7 no irq while busy", {3'b0, irq_n}, 4'h1);
        check("R7 flags while busy", flags, 4'(a ^ b));
        stop = 1; busy = 0; tick();
        stop = 0;
        check("R7 irq at stop", {3'b0, irq_n}, {3'b0, a == b});
      end

    // R5 R8: change captured by a read reload before STOP
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        mask = 4'hF; pins = 4'(a); busy = 1; addr_ack = 1; tick();
        addr_ack = 0; pins = 4'(b); tick();
        rd_ack = 1; tick();
        rd_ack = 0;
        check("R5 flags after read reload", flags, 4'h0);
        stop = 1; busy = 0; tick();
        stop = 0;
        check("R8 irq after stop", {3'b0, irq_n}, 4'h1);
        check("R8 flags after stop", flags, 4'h0);
      end

    // R10: glitch inside a transaction
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        mask = 4'hF; pins = 4'(a); busy = 1; addr_ack = 1; tick();
        addr_ack = 0; pins = 4'(b); tick();
        pins = 4'(a); tick();
        check("R10 no irq mid-glitch", {3'b0, irq_n}, 4'h1);
        stop = 1; busy = 0; tick();
        stop = 0;
        check("R10 flags", flags, 4'(a ^ b));
        check("R10 irq", {3'b0, irq_n}, {3'b0, a == b});
      end

    // R3: idle glitch stays latched
    mask = 4'h0; pins = 4'h5; addr_ack = 1; tick();
    addr_ack = 0; pins = 4'hA; tick();
    pins = 4'h5; tick(); tick(); tick();
    check("R3 latched flags", flags, 4'hF);
    check("R3 masked irq_n", {3'b0, irq_n}, 4'h1);

    // R9: stop/busy without ack keep flags and irq
    mask = 4'h2; pins = 4'h0; addr_ack = 1; tick();
    addr_ack = 0; pins = 4'h2; tick();
    check("R9 irq set", {3'b0, irq_n}, 4'h0);
    busy = 1; tick(); tick();
    stop = 1; busy = 0; tick();
    stop = 0; tick();
    check("R9 irq held", {3'b0, irq_n}, 4'h0);
    check("R9 flags held", flags, 4'h2);
    por_n = 1'b0; pins = 4'hF; tick();
    por_n = 1'b1; tick();
    check("R9 por flags", flags, 4'h0);
    check("R9 por irq_n", {3'b0, irq_n}, 4'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule